// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. Once per clock cycle it looks at a serial line that is already synchronous to `clk`. It acts only in cycles where the oversample strobe `tick` is high, and sixteen strobes make one bit-time. It hunts for a start bit, and it drops any perceived start that turns out to be a glitch. After a confirmed start it takes in 8 or 9 data bits, least-significant bit first, then an optional parity bit and a stop bit. Each bit's value comes from three samples near the middle of the bit.

The serial shifter and the status it builds are private to the block. When a frame completes, the data moves into a parallel holding register and `data_ready` rises. At that same clock edge the noise, parity and framing flags are loaded from what was collected during the frame. Because the holding register is separate from the shifter, the next frame can arrive while the previous one waits to be read. A single-cycle `rd_ack` releases the holding register.

The controller has six states, and `rx_en` low forces every state to IDLE:
- IDLE waits for a high sample and then moves to HUNT.
- HUNT moves to START on a low sample.
- START returns to HUNT (false start) if any sample at ticks 2 to 10 is high. Otherwise it moves to DATA after tick 16.
- DATA stays in DATA from bit to bit. After the last data bit it moves to PARITY, or to STOP when parity is off.
- PARITY moves to STOP.
- STOP moves to HUNT when the stop bit votes high, or to IDLE when it votes low.

Top module: `ovs_serial_rx`

## Requirements
- R1: While `rx_en` is low the line is ignored and no frame completes. A frame cut short by dropping `rx_en` is discarded. After `rx_en` returns high, one high sample is needed before start search resumes.
- R2: In HUNT, a low sample on a tick is tick 1 of a start bit. A high sample at any of ticks 2 to 10 abandons it, and the next tick's sample is examined as a new tick 1.
- R3: A bit-time is 16 ticks. Each bit's value is the majority of its samples at ticks 8, 9 and 10, counted from tick 1 of the start bit.
- R4: Data is received LSB first. With `fmt_nine`=1 there are 9 data bits, placed on `rx_data[8:0]`. With `fmt_nine`=0 there are 8 bits, placed on `rx_data[7:0]`, and `rx_data[8]`=0.
- R5: With `fmt_par_en`=1, a parity bit follows the data. With `fmt_par_odd`=0 the count of ones in data plus parity must be even; with 1 it must be odd. On a mismatch `parity_err` is set.
- R6: A stop bit that votes 0 sets `frame_err`. The receiver then waits for a high sample before hunting again. A stop bit that votes 1 gives no framing error, whatever happened earlier in the frame.
- R7: `noise_err` is set when the three samples of any data, parity or stop bit are not all equal.
- R8: A frame completes on the tick that takes stop-bit sample 10. At that clock edge `rx_data` is loaded, `data_ready` rises, and the noise, parity and framing flags take their new values. At no other time do these flags change, except on `rd_ack`.
- R9: If a frame completes while `data_ready` is high and `rd_ack` is low, `overrun` is set, and `rx_data` and the other three flags keep their values.
- R10: `rd_ack` clears `data_ready`, `noise_err`, `parity_err`, `frame_err` and `overrun` at the next edge, and leaves `rx_data` unchanged.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| tick | input | 1 | Oversample strobe, 16 per bit-time |
| rxd | input | 1 | Serial line, synchronous to clk |
| fmt_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_ack | input | 1 | Holding register read, clears status |
| rx_data | output | 9 | Holding register |
| data_ready | output | 1 | Holding register has unread data |
| noise_err | output | 1 | Non-unanimous bit samples in held frame |
| parity_err | output | 1 | Parity mismatch in held frame |
| frame_err | output | 1 | Stop bit voted low in held frame |
| overrun | output | 1 | A frame was lost because the register was full |

## Verification
The bench targets several corner cases:
- A short low pulse followed by a real start a single tick later. A receiver that fails to restart its tick count would sample every bit at the wrong phase.
- A single flipped sample inside a data bit or inside the stop bit. Either one must set only the noise flag. A receiver that sampled once per bit would corrupt the data or report a framing error.
- A parity bit with two of its three samples flipped, which must give both a parity error and a noise error.
- A stop bit held low, after which the receiver must not read the low line as a new start.
- Frames sent while disabled or cut off by disable, which must leave the holding register as it was.
- A second frame arriving before acknowledge, which must raise overrun and keep the first byte.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } rx_fmt_t;

endpackage

// File: rtl/ovs_rx_vote.sv
// Three-sample majority with disagreement detection.
module ovs_rx_vote (
    input  logic s_a,
    input  logic s_b,
    input  logic s_c,
    output logic level,
    output logic split
);
    always_comb begin
        level = (s_a & s_b) | (s_a & s_c) | (s_b & s_c);
        split = (s_a != s_b) || (s_b != s_c);
    end
endmodule

// File: rtl/ovs_rx_fsm.sv
// Start search, bit timing and frame shifter.
module ovs_rx_fsm
    import ovs_rx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            tick,
    input  logic            rxd,
    input  rx_fmt_t         fmt,
    output logic            frame_done,
    output logic [DMAX-1:0] frame_data,
    output logic            frame_nf,
    output logic            frame_pf,
    output logic            frame_fe
);
    localparam int RT_W = $clog2(OSR + 2);
    localparam int BI_W = $clog2(DMAX + 1);
    localparam logic [RT_W-1:0] RT_ONE  = RT_W'(1);
    localparam logic [RT_W-1:0] RT_LAST = RT_W'(OSR);
    localparam logic [RT_W-1:0] RT_V1   = RT_W'(OSR / 2);
    localparam logic [RT_W-1:0] RT_V2   = RT_W'(OSR / 2 + 1);
    localparam logic [RT_W-1:0] RT_V3   = RT_W'(OSR / 2 + 2);
    localparam logic [BI_W-1:0] NB_LONG  = BI_W'(DMAX);
    localparam logic [BI_W-1:0] NB_SHORT = BI_W'(DMAX - 1);

    rx_state_e       state;
    logic [RT_W-1:0] rt, cur_rt;
    logic [BI_W-1:0] bit_idx, nb_want;
    logic [DMAX-1:0] shreg;
    logic            par_acc, par_bad, noise_acc;
    logic            smp_a, smp_b;
    rx_fmt_t         fmt_q;
    logic            vote, noisy, in_bit;

    ovs_rx_vote u_vote (
        .s_a   (smp_a),
        .s_b   (smp_b),
        .s_c   (rxd),
        .level (vote),
        .split (noisy)
    );

    always_comb begin
        cur_rt  = rt + RT_ONE;
        nb_want = fmt_q.nine ? NB_LONG : NB_SHORT;
        in_bit  = (state == ST_DATA) || (state == ST_PARITY) || (state == ST_STOP);
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rt        <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_acc   <= 1'b0;
            par_bad   <= 1'b0;
            noise_acc <= 1'b0;
            smp_a     <= 1'b0;
            smp_b     <= 1'b0;
            fmt_q     <= '0;
        end else if (!rx_en) begin
            state <= ST_IDLE;
        end else if (tick) begin
            if (in_bit && rt != RT_LAST) begin
                rt <= cur_rt;
                if (cur_rt == RT_V1) smp_a <= rxd;
                if (cur_rt == RT_V2) smp_b <= rxd;
            end
            unique case (state)
                ST_IDLE: if (rxd) state <= ST_HUNT;
                ST_HUNT: begin
                    if (!rxd) begin
                        state <= ST_START;
                        rt    <= RT_ONE;
                    end
                end
                ST_START: begin
                    if (rxd && cur_rt <= RT_V3) begin
                        state <= ST_HUNT;
                    end else if (rt == RT_LAST) begin
                        state     <= ST_DATA;
                        rt        <= RT_ONE;
                        bit_idx   <= '0;
                        shreg     <= '0;
                        par_acc   <= 1'b0;
                        par_bad   <= 1'b0;
                        noise_acc <= 1'b0;
                        fmt_q     <= fmt;
                    end else begin
                        rt <= cur_rt;
                    end
                end
                ST_DATA: begin
                    if (rt == RT_LAST) begin
                        rt <= RT_ONE;
                        if (bit_idx == nb_want)
                            state <= fmt_q.par_en ? ST_PARITY : ST_STOP;
                    end else if (cur_rt == RT_V3) begin
                        shreg[bit_idx] <= vote;
                        par_acc        <= par_acc ^ vote;
                        noise_acc      <= noise_acc | noisy;
                        bit_idx        <= bit_idx + BI_W'(1);
                    end
                end
                ST_PARITY: begin
                    if (rt == RT_LAST) begin
                        rt    <= RT_ONE;
                        state <= ST_STOP;
                    end else if (cur_rt == RT_V3) begin
                        par_bad   <= (par_acc ^ vote) != fmt_q.par_odd;
                        noise_acc <= noise_acc | noisy;
                    end
                end
                ST_STOP: if (cur_rt == RT_V3) state <= vote ? ST_HUNT : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output process.
    always_comb begin
        frame_done = rx_en && tick && (state == ST_STOP) && (cur_rt == RT_V3);
        frame_data = shreg;
        frame_nf   = noise_acc | noisy;
        frame_pf   = par_bad;
        frame_fe   = !vote;
    end
endmodule

// File: rtl/ovs_rx_hold.sv
// Parallel holding register with status flags.
module ovs_rx_hold #(
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DMAX-1:0] ld_data,
    input  logic            ld_nf,
    input  logic            ld_pf,
    input  logic            ld_fe,
    input  logic            rd_ack,
    output logic [DMAX-1:0] rx_data,
    output logic            data_ready,
    output logic            noise_err,
    output logic            parity_err,
    output logic            frame_err,
    output logic            overrun
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            noise_err  <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else if (load && data_ready && !rd_ack) begin
            overrun <= 1'b1;
        end else if (load) begin
            rx_data    <= ld_data;
            data_ready <= 1'b1;
            noise_err  <= ld_nf;
            parity_err <= ld_pf;
            frame_err  <= ld_fe;
            overrun    <= 1'b0;
        end else if (rd_ack) begin
            data_ready <= 1'b0;
            noise_err  <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end
    end
endmodule

// File: rtl/ovs_serial_rx.sv
module ovs_serial_rx
    import ovs_rx_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            tick,
    input  logic            rxd,
    input  logic            fmt_nine,
    input  logic            fmt_par_en,
    input  logic            fmt_par_odd,
    input  logic            rd_ack,
    output logic [DMAX-1:0] rx_data,
    output logic            data_ready,
    output logic            noise_err,
    output logic            parity_err,
    output logic            frame_err,
    output logic            overrun
);
    rx_fmt_t         fmt;
    logic            frame_done, frame_nf, frame_pf, frame_fe;
    logic [DMAX-1:0] frame_data;

    always_comb begin
        fmt.nine    = fmt_nine;
        fmt.par_en  = fmt_par_en;
        fmt.par_odd = fmt_par_odd;
    end

    ovs_rx_fsm #(.OSR(OSR), .DMAX(DMAX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .tick       (tick),
        .rxd        (rxd),
        .fmt        (fmt),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .frame_nf   (frame_nf),
        .frame_pf   (frame_pf),
        .frame_fe   (frame_fe)
    );

    ovs_rx_hold #(.DMAX(DMAX)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (frame_done),
        .ld_data    (frame_data),
        .ld_nf      (frame_nf),
        .ld_pf      (frame_pf),
        .ld_fe      (frame_fe),
        .rd_ack     (rd_ack),
        .rx_data    (rx_data),
        .data_ready (data_ready),
        .noise_err  (noise_err),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );
endmodule

// File: rtl/ovs_rx_checker.sv
module ovs_rx_checker #(
    parameter int DMAX = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_en,
    input logic            tick,
    input logic            rd_ack,
    input logic            frame_done,
    input logic [DMAX-1:0] rx_data,
    input logic            data_ready,
    input logic            noise_err,
    input logic            parity_err,
    input logic            frame_err,
    input logic            overrun
);
    a_r8_ready_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(frame_done));

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_done && !rd_ack) |=> $stable({noise_err, parity_err, frame_err}));

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !frame_done) |=>
            !(data_ready || noise_err || parity_err || frame_err || overrun));

    a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && data_ready && !rd_ack) |=> (overrun && $stable(rx_data)));

    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frame_done);

    a_r3_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> tick);
endmodule

bind ovs_serial_rx ovs_rx_checker #(.DMAX(DMAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .tick       (tick),
    .rd_ack     (rd_ack),
    .frame_done (frame_done),
    .rx_data    (rx_data),
    .data_ready (data_ready),
    .noise_err  (noise_err),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .overrun    (overrun)
);

// File: tb/ovs_serial_rx_tb.sv
`timescale 1ns/100ps
module ovs_serial_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       fmt_nine = 1'b0, fmt_par_en = 1'b0, fmt_par_odd = 1'b0;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       data_ready, noise_err, parity_err, frame_err, overrun;

    int errors = 0;
    int checks = 0;
    bit live = 1'b0;

    // Reference model state.
    logic [8:0] e_data = '0;
    logic       e_ready = 0, e_nf = 0, e_pf = 0, e_fe = 0, e_ov = 0;
    logic [8:0] p_data;
    logic       p_nf, p_pf, p_fe;

    logic       smp [0:191];

    always #2.5 clk = ~clk;

    ovs_serial_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .rxd(rxd),
        .fmt_nine(fmt_nine), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
        .rd_ack(rd_ack), .rx_data(rx_data), .data_ready(data_ready),
        .noise_err(noise_err), .parity_err(parity_err), .frame_err(frame_err),
        .overrun(overrun)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (live) begin
            cmp("R4", "rx_data",    rx_data,           e_data);
            cmp("R8", "data_ready", {8'd0, data_ready}, {8'd0, e_ready});
            cmp("R7", "noise_err",  {8'd0, noise_err},  {8'd0, e_nf});
            cmp("R5", "parity_err", {8'd0, parity_err}, {8'd0, e_pf});
            cmp("R6", "frame_err",  {8'd0, frame_err},  {8'd0, e_fe});
            cmp("R9", "overrun",    {8'd0, overrun},    {8'd0, e_ov});
        end
    end

    task automatic model_frame();
        if (e_ready) e_ov = 1'b1;
        else begin
            e_data = p_data; e_nf = p_nf; e_pf = p_pf; e_fe = p_fe; e_ready = 1'b1;
        end
    endtask

    task automatic put_sample(input logic b, input bit ev);
        repeat (3) begin @(negedge clk); tick = 1'b0; end
        @(negedge clk); tick = 1'b1; rxd = b;
        @(posedge clk);
        if (ev) model_frame();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put_sample(1'b1, 1'b0);
    endtask

    task automatic ack();
        @(negedge clk); tick = 1'b0; rd_ack = 1'b1;
        @(posedge clk);
        e_ready = 0; e_nf = 0; e_pf = 0; e_fe = 0; e_ov = 0;
        @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); tick = 1'b0; rx_en = v;
    endtask

    // Builds and plays one frame; g0/g1 flip single samples (-1 = none);
    // cut_at >= 0 drops rx_en before that sample index.
    task automatic send_frame(input logic [8:0] d, input bit nine, input bit pen,
                              input bit odd, input logic stopv, input int g0,
                              input int g1, input bit expect_it, input int cut_at);
        int nd, nb, len, ev;
        logic a, b, c, m, pv, acc;
        logic [8:0] dv;
        bit nz;
        nd = nine ? 9 : 8;
        nb = 1 + nd + (pen ? 1 : 0) + 1;
        len = nb * 16;
        @(negedge clk); tick = 1'b0;
        fmt_nine = nine; fmt_par_en = pen; fmt_par_odd = odd;
        for (int k = 0; k < nb; k++) begin
            logic v;
            if (k == 0) v = 1'b0;
            else if (k <= nd) v = d[k-1];
            else if (pen && k == nd + 1) begin
                v = odd;
                for (int j = 0; j < nd; j++) v = v ^ d[j];
            end else v = stopv;
            for (int t = 0; t < 16; t++) smp[k*16+t] = v;
        end
        if (g0 >= 0) smp[g0] = ~smp[g0];
        if (g1 >= 0) smp[g1] = ~smp[g1];
        dv = '0; nz = 0; acc = 0; pv = 0; m = 1'b1;
        for (int k = 1; k < nb; k++) begin
            a = smp[k*16+7]; b = smp[k*16+8]; c = smp[k*16+9];
            m = (a & b) | (a & c) | (b & c);
            if (!(a == b && b == c)) nz = 1;
            if (k <= nd) begin dv[k-1] = m; acc = acc ^ m; end
            else if (pen && k == nd + 1) pv = ((acc ^ m) != odd);
        end
        p_data = dv; p_nf = nz; p_pf = pen ? pv : 1'b0; p_fe = !m;
        ev = (nb - 1) * 16 + 9;
        for (int i = 0; i < len; i++) begin
            if (i == cut_at) set_en(1'b0);
            put_sample(smp[i], expect_it && (i == ev));
        end
    endtask

    task automatic spot(input string tag, input logic [8:0] d, input logic rdy);
        #1;
        cmp(tag, "rx_data", rx_data, d);
        cmp(tag, "data_ready", {8'd0, data_ready}, {8'd0, rdy});
    endtask

    initial begin
        #300000;
        errors++; checks++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11: everything zero out of reset
        cmp("R11", "outputs", {rx_data}, 9'd0);
        cmp("R11", "flags", {4'd0, data_ready, noise_err, parity_err, frame_err, overrun}, 9'd0);
        live = 1'b1;
        idle(20);

        // R4: 8-bit, no parity, LSB first
        send_frame(9'h0A5, 0, 0, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R4", 9'h0A5, 1'b1);
        ack(); spot("R10", 9'h0A5, 1'b0);

        // R4/R5: 9-bit, even parity, no error
        send_frame(9'h1C3, 1, 1, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R4", 9'h1C3, 1'b1);
        ack();

        // R5/R7: odd parity, two of three parity samples flipped
        send_frame(9'h05A, 0, 1, 1, 1'b1, 9*16+7, 9*16+8, 1, -1);
        idle(8); ack();

        // R3/R7: one sample flipped in bit 3 of the data
        send_frame(9'h0F0, 0, 0, 0, 1'b1, 4*16+8, -1, 1, -1);
        idle(8); spot("R3", 9'h0F0, 1'b1); ack();

        // R6: stop bit low, then recovery
        send_frame(9'h033, 0, 0, 0, 1'b0, -1, -1, 1, -1);
        idle(10); ack();
        send_frame(9'h081, 0, 0, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R6", 9'h081, 1'b1); ack();

        // R7/R6: single low sample inside stop bit: noise only
        send_frame(9'h07E, 0, 0, 0, 1'b1, 9*16+9, -1, 1, -1);
        idle(8); ack();

        // R9: second frame before ack
        send_frame(9'h011, 0, 0, 0, 1'b1, -1, -1, 1, -1);
        idle(8);
        send_frame(9'h0EE, 0, 1, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R9", 9'h011, 1'b1); ack();

        // R2: short glitch, then short low followed directly by real start
        put_sample(0, 0); put_sample(0, 0); put_sample(0, 0); put_sample(1, 0);
        idle(5);
        for (int i = 0; i < 6; i++) put_sample(0, 0);
        put_sample(1, 0);
        send_frame(9'h03C, 0, 0, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R2", 9'h03C, 1'b1); ack();

        // R1: disabled receiver ignores a full frame
        set_en(1'b0);
        send_frame(9'h055, 0, 0, 0, 1'b1, -1, -1, 0, -1);
        idle(8); spot("R1", 9'h03C, 1'b0);
        set_en(1'b1); idle(4);
        send_frame(9'h0C9, 0, 0, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R1", 9'h0C9, 1'b1); ack();

        // R1: frame cut by disable is discarded
        send_frame(9'h0AA, 0, 0, 0, 1'b1, -1, -1, 0, 60);
        idle(8); spot("R1", 9'h0C9, 1'b0);
        set_en(1'b1); idle(4);
        send_frame(9'h16D, 1, 0, 0, 1'b1, -1, -1, 1, -1);
        idle(8); spot("R4", 9'h16D, 1'b1); ack();

        idle(4);
        live = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule